// File: doc/BRIEF.md
# Pipelined Multiply-Add Execution Unit

This block is the arithmetic core of a small 32-bit processor pipeline. Each cycle it accepts one operation with its operands: two 32-bit register values, a 16-bit multiplier operand, a 32-bit accumulator operand and a 16-bit immediate. It returns the low 32 bits of the result, a write-back qualifier and four condition flags exactly four cycles later. A new operation can enter every cycle.

Inside, a 48-bit three-input datapath evaluates either `X op Y` or `X op (M1 × M2)`. An operand-steering stage spreads the 32-bit operands over a 30-bit high port, an 18-bit low port and a 48-bit addend port. Depending on the operation class, it sign-extends, splits or forces each port to zero. The operation controls are registered alongside their data at every stage, so consecutive operations of different kinds never share a control setting.

Top module: `mac_exec_unit`

## Requirements
- R1: ADD (op 1) gives `ra + rb` and SUB (op 3) gives `ra - rb`, modulo 2^32, for any 32-bit operand values.
- R2: ADDI (op 2) and SUBI (op 4) use `imm[10:0]` sign-extended to 32 bits in place of `rb`, and ignore `imm[15:11]`.
- R3: MUL (op 5) gives the 32-bit signed product of `rb[15:0]` and `rc[15:0]`. The values of `ra`, `rp` and `rb[31:16]` have no effect on the result.
- R4: MADD (op 7) gives `ra + P`, MSUB (op 8) gives `ra - P`, and MAC (op 6) gives `rp + P`, where P is the signed 16×16 product of R3.
- R5: the bitwise operations combine `ra` with `rb` as follows: AND (op 9), OR (10), XOR (11), XNOR (12), NOR (13) and NAND (14). NOT (op 15) gives `~rb`.
- R6: MOV (op 16) gives `ra`. MOVL (op 17) gives `imm[15:0]` zero-extended to 32 bits.
- R7: an operation accepted with `in_valid` high at a clock edge appears with `out_valid` high at the fourth following edge. Operations issued on consecutive cycles come out in order on consecutive cycles, and no output appears without an accepted operation.
- R8: `flag_z` is set when the result is zero, and `flag_n` copies result bit 31, for every operation. For add, subtract and compare operations, `flag_c` is the unsigned carry (for subtraction: no borrow, i.e. first operand ≥ second unsigned) and `flag_v` is signed 32-bit overflow. Both are 0 for all other operations.
- R9: CMP (op 18) and CMPI (op 19) produce the same result and flags as SUB and SUBI, but with `wb_en` low. NOP (op 0) produces result 0 with `wb_en` low. All other accepted operations raise `wb_en` with `out_valid`.
- R10: alternating multiply and non-multiply operations on consecutive cycles each produce the result of their own operation.
- R11: while `rst_n` is low at a clock edge the pipeline is emptied. After reset, `out_valid` and `wb_en` stay low until an operation issued after reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Accept an operation this cycle |
| op | input | 5 | Operation code (see requirements) |
| ra | input | 32 | First register operand |
| rb | input | 32 | Second register operand; low 16 bits are the first multiplier operand |
| rc | input | 16 | Second multiplier operand |
| rp | input | 32 | Accumulator operand for MAC |
| imm | input | 16 | Immediate (11-bit signed for ADDI/SUBI/CMPI, 16-bit for MOVL) |
| out_valid | output | 1 | Result present |
| wb_en | output | 1 | Result should be written back |
| result | output | 32 | Low 32 bits of the datapath result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 31 |
| flag_c | output | 1 | Unsigned carry / no borrow |
| flag_v | output | 1 | Signed overflow |

## Verification
The situation hardest to reach from the ports has two parts. One is a multiply and a non-multiply operation standing in adjacent pipeline stages, where a control shared between stages would corrupt one of them. The other is operands that sit exactly on the 32-bit carry and overflow boundaries. The stimulus issues directed back-to-back alternations of MUL/MADD/MAC with ADD/SUB/logic operations, then a long random sequence with idle gaps. That sequence draws operands from a mix of corner values (0, all-ones, the most positive and most negative words, and the 16-bit extremes) and uniform random words. Every result is compared four cycles later against a behavioural model kept in the bench.

// File: rtl/mxu_pkg.sv
// Shared operation codes, datapath function codes and the per-stage
// control word of the multiply-add execution unit.
package mxu_pkg;

    typedef enum logic [4:0] {
        OP_NOP  = 5'd0,  OP_ADD  = 5'd1,  OP_ADDI = 5'd2,  OP_SUB  = 5'd3,
        OP_SUBI = 5'd4,  OP_MUL  = 5'd5,  OP_MAC  = 5'd6,  OP_MADD = 5'd7,
        OP_MSUB = 5'd8,  OP_AND  = 5'd9,  OP_OR   = 5'd10, OP_XOR  = 5'd11,
        OP_XNOR = 5'd12, OP_NOR  = 5'd13, OP_NAND = 5'd14, OP_NOT  = 5'd15,
        OP_MOV  = 5'd16, OP_MOVL = 5'd17, OP_CMP  = 5'd18, OP_CMPI = 5'd19
    } mxu_op_e;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_XNOR, FN_NOR, FN_NAND, FN_NOTX
    } mxu_fn_e;

    typedef struct packed {
        logic    valid;     // stage holds an accepted operation
        logic    wb;        // result is to be written back
        logic    use_mult;  // second operand is the product, not {hi:lo}
        logic    arith;     // carry and overflow flags are meaningful
        mxu_fn_e fn;        // datapath function
    } mxu_ctrl_t;

endpackage

// File: rtl/mxu_operand_map.sv
// Operand steering (combinational). Decodes the operation code and spreads
// the 32-bit operands over the narrow high, low and addend ports.
// Assumes HI_W + LO_W == P_W and that P_W exceeds DATA_W.
module mxu_operand_map
    import mxu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 30,
    parameter int LO_W   = 18,
    parameter int P_W    = 48,
    parameter int MUL_W  = 16,
    parameter int IMMS_W = 11,
    parameter int IMML_W = 16
) (
    input  logic [4:0]        op_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] ra_i,
    input  logic [DATA_W-1:0] rb_i,
    input  logic [MUL_W-1:0]  rc_i,
    input  logic [DATA_W-1:0] rp_i,
    input  logic [IMML_W-1:0] imm_i,
    output logic [HI_W-1:0]   hi_o,
    output logic [LO_W-1:0]   lo_o,
    output logic [P_W-1:0]    add_o,
    output mxu_ctrl_t         ctrl_o
);
    localparam int RB_UP_W = DATA_W - LO_W;   // rb bits that land on the high port

    logic [HI_W-1:0] hi_split, hi_mul, hi_imm;
    logic [LO_W-1:0] lo_imm, lo_mul;
    logic [P_W-1:0]  add_ra, add_rp, add_movl;

    // Candidate port values for each operation class
    assign hi_split = {{(HI_W-RB_UP_W){rb_i[DATA_W-1]}}, rb_i[DATA_W-1:LO_W]};
    assign hi_mul   = {{(HI_W-MUL_W){rb_i[MUL_W-1]}}, rb_i[MUL_W-1:0]};
    assign hi_imm   = {HI_W{imm_i[IMMS_W-1]}};
    assign lo_imm   = {{(LO_W-IMMS_W){imm_i[IMMS_W-1]}}, imm_i[IMMS_W-1:0]};
    assign lo_mul   = {{(LO_W-MUL_W){rc_i[MUL_W-1]}}, rc_i};
    assign add_ra   = {{(P_W-DATA_W){ra_i[DATA_W-1]}}, ra_i};
    assign add_rp   = {{(P_W-DATA_W){rp_i[DATA_W-1]}}, rp_i};
    assign add_movl = {{(P_W-IMML_W){1'b0}}, imm_i};

    // Decode: choose port contents and control word per operation
    always_comb begin
        hi_o   = hi_split;
        lo_o   = rb_i[LO_W-1:0];
        add_o  = add_ra;
        ctrl_o = '{valid: valid_i, wb: 1'b1, use_mult: 1'b0, arith: 1'b0, fn: FN_ADD};
        case (mxu_op_e'(op_i))
            OP_ADD:  ctrl_o.arith = 1'b1;
            OP_SUB:  begin ctrl_o.arith = 1'b1; ctrl_o.fn = FN_SUB; end
            OP_CMP:  begin ctrl_o.arith = 1'b1; ctrl_o.fn = FN_SUB; ctrl_o.wb = 1'b0; end
            OP_ADDI: begin hi_o = hi_imm; lo_o = lo_imm; ctrl_o.arith = 1'b1; end
            OP_SUBI: begin hi_o = hi_imm; lo_o = lo_imm; ctrl_o.arith = 1'b1;
                           ctrl_o.fn = FN_SUB; end
            OP_CMPI: begin hi_o = hi_imm; lo_o = lo_imm; ctrl_o.arith = 1'b1;
                           ctrl_o.fn = FN_SUB; ctrl_o.wb = 1'b0; end
            OP_MUL:  begin hi_o = hi_mul; lo_o = lo_mul; add_o = '0; ctrl_o.use_mult = 1'b1; end
            OP_MADD: begin hi_o = hi_mul; lo_o = lo_mul; ctrl_o.use_mult = 1'b1; end
            OP_MSUB: begin hi_o = hi_mul; lo_o = lo_mul; ctrl_o.use_mult = 1'b1;
                           ctrl_o.fn = FN_SUB; end
            OP_MAC:  begin hi_o = hi_mul; lo_o = lo_mul; add_o = add_rp; ctrl_o.use_mult = 1'b1; end
            OP_AND:  ctrl_o.fn = FN_AND;
            OP_OR:   ctrl_o.fn = FN_OR;
            OP_XOR:  ctrl_o.fn = FN_XOR;
            OP_XNOR: ctrl_o.fn = FN_XNOR;
            OP_NOR:  ctrl_o.fn = FN_NOR;
            OP_NAND: ctrl_o.fn = FN_NAND;
            OP_NOT:  ctrl_o.fn = FN_NOTX;
            OP_MOV:  begin hi_o = '0; lo_o = '0; end
            OP_MOVL: begin hi_o = '0; lo_o = '0; add_o = add_movl; end
            default: begin hi_o = '0; lo_o = '0; add_o = '0; ctrl_o.wb = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mxu_mult_stage.sv
// Second pipeline stage: forms the second datapath operand, either the
// signed product of the high and low ports or their concatenation.
// Assumes HI_W + LO_W == P_W, so the full product fits without loss.
module mxu_mult_stage
    import mxu_pkg::*;
#(
    parameter int HI_W = 30,
    parameter int LO_W = 18,
    parameter int P_W  = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [HI_W-1:0] hi_i,
    input  logic [LO_W-1:0] lo_i,
    input  logic [P_W-1:0]  add_i,
    input  mxu_ctrl_t       ctrl_i,
    output logic [P_W-1:0]  opx_o,
    output logic [P_W-1:0]  add_o,
    output mxu_ctrl_t       ctrl_o
);
    logic signed [P_W-1:0] prod;

    // Signed multiply of the two narrow ports
    always_comb prod = $signed(hi_i) * $signed(lo_i);

    // Register the chosen operand, addend and control together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else begin
            ctrl_o <= ctrl_i;
        end
        opx_o <= ctrl_i.use_mult ? prod : {hi_i, lo_i};
        add_o <= add_i;
    end
endmodule

// File: rtl/mxu_alu_stage.sv
// Third pipeline stage: 48-bit add/subtract/bitwise unit. Also carries the
// bit-31 signs of both inputs forward for the carry flag.
// Assumes DATA_W < P_W.
module mxu_alu_stage
    import mxu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int P_W    = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] opx_i,
    input  logic [P_W-1:0] add_i,
    input  mxu_ctrl_t      ctrl_i,
    output logic [P_W-1:0] p_o,
    output logic           sgn_add_o,
    output logic           sgn_x_o,
    output mxu_ctrl_t      ctrl_o
);
    logic [P_W-1:0] alu;

    // Datapath function selected by the control travelling with the data
    always_comb begin
        case (ctrl_i.fn)
            FN_SUB:  alu = add_i - opx_i;
            FN_AND:  alu = add_i & opx_i;
            FN_OR:   alu = add_i | opx_i;
            FN_XOR:  alu = add_i ^ opx_i;
            FN_XNOR: alu = ~(add_i ^ opx_i);
            FN_NOR:  alu = ~(add_i | opx_i);
            FN_NAND: alu = ~(add_i & opx_i);
            FN_NOTX: alu = ~opx_i;
            default: alu = add_i + opx_i;
        endcase
    end

    // Register the result, the operand signs and the control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o <= '0;
        end else begin
            ctrl_o <= ctrl_i;
        end
        p_o       <= alu;
        sgn_add_o <= add_i[DATA_W-1];
        sgn_x_o   <= opx_i[DATA_W-1];
    end
endmodule

// File: rtl/mac_exec_unit.sv
// Top of the pipelined multiply-add execution unit. Stage 1 registers the
// steered operands, stage 2 multiplies or concatenates, stage 3 runs the
// 48-bit function, and stage 4 registers the low word and the flags.
// Latency is four clocks at one operation per clock. Assumes the
// operands arrive with in_valid in the same cycle.
module mac_exec_unit
    import mxu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 30,
    parameter int LO_W   = 18,
    parameter int MUL_W  = 16,
    parameter int IMMS_W = 11,
    parameter int IMML_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] ra,
    input  logic [DATA_W-1:0] rb,
    input  logic [MUL_W-1:0]  rc,
    input  logic [DATA_W-1:0] rp,
    input  logic [IMML_W-1:0] imm,
    output logic              out_valid,
    output logic              wb_en,
    output logic [DATA_W-1:0] result,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              flag_v
);
    localparam int P_W = HI_W + LO_W;

    logic [HI_W-1:0] m_hi, s1_hi;
    logic [LO_W-1:0] m_lo, s1_lo;
    logic [P_W-1:0]  m_add, s1_add, s2_x, s2_add, s3_p;
    mxu_ctrl_t       m_ctrl, s1_ctrl, s2_ctrl, s3_ctrl;
    logic            s3_sa, s3_sx, carry32, ovf32;

    mxu_operand_map #(
        .DATA_W(DATA_W), .HI_W(HI_W), .LO_W(LO_W), .P_W(P_W),
        .MUL_W(MUL_W), .IMMS_W(IMMS_W), .IMML_W(IMML_W)
    ) u_map (
        .op_i(op), .valid_i(in_valid), .ra_i(ra), .rb_i(rb), .rc_i(rc),
        .rp_i(rp), .imm_i(imm), .hi_o(m_hi), .lo_o(m_lo), .add_o(m_add),
        .ctrl_o(m_ctrl)
    );

    // Stage 1: capture steered operands and their control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_ctrl <= '0;
        end else begin
            s1_ctrl <= m_ctrl;
        end
        s1_hi  <= m_hi;
        s1_lo  <= m_lo;
        s1_add <= m_add;
    end

    mxu_mult_stage #(.HI_W(HI_W), .LO_W(LO_W), .P_W(P_W)) u_mult (
        .clk(clk), .rst_n(rst_n), .hi_i(s1_hi), .lo_i(s1_lo), .add_i(s1_add),
        .ctrl_i(s1_ctrl), .opx_o(s2_x), .add_o(s2_add), .ctrl_o(s2_ctrl)
    );

    mxu_alu_stage #(.DATA_W(DATA_W), .P_W(P_W)) u_alu (
        .clk(clk), .rst_n(rst_n), .opx_i(s2_x), .add_i(s2_add), .ctrl_i(s2_ctrl),
        .p_o(s3_p), .sgn_add_o(s3_sa), .sgn_x_o(s3_sx), .ctrl_o(s3_ctrl)
    );

    // Carry out of bit 31 recovered from the sign-extended sum;
    // overflow when the bits above the word do not all match bit 31
    always_comb begin
        carry32 = s3_p[DATA_W] ^ s3_sa ^ (s3_ctrl.fn == FN_SUB ? ~s3_sx : s3_sx);
        ovf32   = ~((&s3_p[P_W-1:DATA_W-1]) | ~(|s3_p[P_W-1:DATA_W-1]));
    end

    // Stage 4: output register with flags and write-back qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wb_en     <= 1'b0;
        end else begin
            out_valid <= s3_ctrl.valid;
            wb_en     <= s3_ctrl.valid & s3_ctrl.wb;
        end
        result <= s3_p[DATA_W-1:0];
        flag_z <= ~(|s3_p[DATA_W-1:0]);
        flag_n <= s3_p[DATA_W-1];
        flag_c <= s3_ctrl.arith & carry32;
        flag_v <= s3_ctrl.arith & ovf32;
    end

    AST_LATENCY_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid); // R7
    AST_MUL_ADDEND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_MUL) |=> (s1_add == '0)); // R3
    AST_POS_IMM_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_ADDI || op == OP_SUBI || op == OP_CMPI) && !imm[IMMS_W-1])
        |=> (s1_hi == '0)); // R2
    AST_CMP_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_CMP || op == OP_CMPI)) |-> ##4 (out_valid && !wb_en)); // R9
    AST_MUL_CTRL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_ctrl.valid && s1_ctrl.use_mult) |=> (s2_ctrl.valid && s2_ctrl.use_mult)); // R10
    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid); // R11
endmodule

// File: tb/tb_mac_exec_unit.sv
module tb_mac_exec_unit;
    import mxu_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [31:0] ra = '0, rb = '0, rp = '0;
    logic [15:0] rc = '0, imm = '0;
    logic        out_valid, wb_en, flag_z, flag_n, flag_c, flag_v;
    logic [31:0] result;

    typedef struct {
        logic [31:0] res;
        logic        z, n, c, v, wb;
        int          op;
        int          cyc;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   n_chk = 0, n_fail = 0, cyc = 0;
    bit   done = 1'b0;

    mac_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .ra(ra), .rb(rb),
        .rc(rc), .rp(rp), .imm(imm), .out_valid(out_valid), .wb_en(wb_en),
        .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
        .flag_v(flag_v)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string req_of(int o);
        case (o)
            1, 3:              return "R1";
            2, 4:              return "R2";
            5:                 return "R3";
            6, 7, 8:           return "R4";
            9, 10, 11, 12, 13, 14, 15: return "R5";
            16, 17:            return "R6";
            default:           return "R9";
        endcase
    endfunction

    // Behavioural model written from the requirements
    function automatic exp_t model(int o, logic [31:0] a, logic [31:0] b,
                                   logic [15:0] c16, logic [31:0] p, logic [15:0] im);
        exp_t e;
        logic [31:0] x;
        logic [32:0] s;
        logic signed [31:0] pr;
        bit arith = 0, sub = 0;
        pr = $signed(b[15:0]) * $signed(c16);
        x  = b;
        case (o)
            1: begin arith = 1; end
            2: begin arith = 1; x = {{21{im[10]}}, im[10:0]}; end
            3, 18: begin arith = 1; sub = 1; end
            4, 19: begin arith = 1; sub = 1; x = {{21{im[10]}}, im[10:0]}; end
            default: ;
        endcase
        e.c = 0; e.v = 0;
        if (arith && !sub) begin
            s = {1'b0, a} + {1'b0, x};
            e.res = s[31:0]; e.c = s[32];
            e.v = (a[31] == x[31]) && (e.res[31] != a[31]);
        end else if (arith) begin
            e.res = a - x; e.c = (a >= x);
            e.v = (a[31] != x[31]) && (e.res[31] != a[31]);
        end else begin
            case (o)
                5:  e.res = pr;
                6:  e.res = p + pr;
                7:  e.res = a + pr;
                8:  e.res = a - pr;
                9:  e.res = a & b;
                10: e.res = a | b;
                11: e.res = a ^ b;
                12: e.res = ~(a ^ b);
                13: e.res = ~(a | b);
                14: e.res = ~(a & b);
                15: e.res = ~b;
                16: e.res = a;
                17: e.res = {16'h0, im};
                default: e.res = 32'h0;
            endcase
        end
        e.z  = (e.res == 32'h0);
        e.n  = e.res[31];
        e.wb = !(o == 0 || o == 18 || o == 19);
        e.op = o;
        e.cyc = 0;
        return e;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: issue one operation and push its expected outcome
    task automatic issue(int o, logic [31:0] a, logic [31:0] b, logic [15:0] c16,
                         logic [31:0] p, logic [15:0] im);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; op = 5'(o); ra = a; rb = b; rc = c16; rp = p; imm = im;
        e = model(o, a, b, c16, p, im);
        e.cyc = cyc;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        op = 5'($urandom_range(0, 19)); ra = $urandom; rb = $urandom;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return {$urandom_range(0, 1) ? 16'hFFFF : 16'h0, 16'h8000};
            5: return {16'($urandom), 16'h7FFF};
            default: return $urandom;
        endcase
    endfunction

    // Monitor: pop and compare as results come out
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "output without operation", 64'(out_valid), 64'h0);
                end else begin
                    mon_e = q.pop_front();
                    chk(result == mon_e.res, req_of(mon_e.op), "result",
                        64'(result), 64'(mon_e.res));
                    chk({flag_z, flag_n, flag_c, flag_v} ==
                        {mon_e.z, mon_e.n, mon_e.c, mon_e.v}, "R8", "flags zncv",
                        64'({flag_z, flag_n, flag_c, flag_v}),
                        64'({mon_e.z, mon_e.n, mon_e.c, mon_e.v}));
                    chk(wb_en == mon_e.wb, "R9", "wb_en", 64'(wb_en), 64'(mon_e.wb));
                    chk(cyc - mon_e.cyc == 4, "R7", "latency", 64'(cyc - mon_e.cyc), 64'd4);
                end
            end else if (wb_en) begin
                chk(1'b0, "R11", "wb_en without out_valid", 64'(wb_en), 64'h0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R11: operations presented during reset are discarded
        in_valid = 1'b1; op = 5'(OP_ADD);
        repeat (3) @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        repeat (5) begin
            @(negedge clk);
            chk(!out_valid && !wb_en, "R11", "idle after reset",
                64'({out_valid, wb_en}), 64'h0);
        end

        // R1 / R8 carry and overflow edges
        issue(1, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0);
        issue(1, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0);
        issue(3, 32'h0000_0005, 32'h0000_0005, 0, 0, 0);
        issue(3, 32'h8000_0000, 32'h0000_0001, 0, 0, 0);
        issue(3, 32'h0000_0001, 32'h0000_0002, 0, 0, 0);
        // R2 immediates, negative and positive, upper imm bits set
        issue(2, 32'h0000_0010, 0, 0, 0, 16'hF7FF);
        issue(4, 32'h0000_0000, 0, 0, 0, 16'h0400);
        issue(2, 32'h1234_5678, 0, 0, 0, 16'h03FF);
        // R3 multiply with garbage in ignored bits
        issue(5, 32'hDEAD_BEEF, 32'hABCD_8000, 16'h8000, 32'hFFFF_FFFF, 0);
        issue(5, 32'h1111_1111, 32'h5555_7FFF, 16'hFFFF, 32'h2222_2222, 0);
        // R4 multiply-accumulate forms
        issue(7, 32'h0000_0100, 32'h0000_0010, 16'h0010, 32'h9999_9999, 0);
        issue(8, 32'h0000_0000, 32'h0000_0003, 16'hFFFE, 0, 0);
        issue(6, 32'hCAFE_F00D, 32'h0000_0002, 16'h0003, 32'h7FFF_FFFA, 0);
        // R5 logic, R6 moves
        for (int o = 9; o <= 15; o++) issue(o, 32'hF0F0_3C3C, 32'hFF00_5A5A, 0, 0, 0);
        issue(16, 32'h8765_4321, 32'h1, 0, 0, 0);
        issue(17, 32'hFFFF_FFFF, 32'h1, 0, 0, 16'hFFFF);
        // R9 compare and nop
        issue(18, 32'h0000_0007, 32'h0000_0007, 0, 0, 0);
        issue(19, 32'h0000_0000, 0, 0, 0, 16'h07FF);
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        // R10 back-to-back alternation of multiply and non-multiply
        for (int i = 0; i < 24; i++) begin
            case (i % 4)
                0: issue(5, pick(), pick(), 16'($urandom), pick(), 0);
                1: issue(1, pick(), pick(), 16'($urandom), pick(), 0);
                2: issue(6 + (i % 3), pick(), pick(), 16'($urandom), pick(), 0);
                default: issue(9 + (i % 7), pick(), pick(), 16'($urandom), pick(), 0);
            endcase
        end
        // Random mix with idle gaps
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 5) == 0) idle();
            else issue($urandom_range(0, 19), pick(), pick(), 16'(pick()), pick(),
                       16'(pick()));
        end
        idle();
        repeat (8) @(negedge clk);
        chk(q.size() == 0, "R7", "all operations returned", 64'(q.size()), 64'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule